// File: doc/BRIEF.md
# Audio Direction Status and Interrupt Register

This block is the control and status word for one direction (transmit or receive) of a serial audio port. It sits behind a simple single-word 32-bit register interface. A write updates the word in the cycle of the write strobe. The read value is always present on `rd_data`.

The word holds five event flags, with an interrupt enable for each one. It also holds a DMA request enable, a software reset bit, a self-clearing FIFO reset bit and the direction enable. Three of the flags latch pulses from the serializer and the FIFO, and writing 1 clears them. The other two show the FIFO's present condition. The block drives an interrupt line, a gated DMA request, a one-cycle FIFO pointer reset, a direction reset level and a direction enable.

The direction enable is a three-state machine:
- States: `EN_IDLE`, `EN_RUN` and `EN_DRAIN`.
- Transitions: `go` (IDLE/DRAIN to RUN on a write with bit 31 = 1), `stop` (RUN to DRAIN on a write with bit 31 = 0), `frame_done` (DRAIN to IDLE on `frame_end`) and `sw_reset` (any state to IDLE while the software reset bit is 1).
- Priority: `go` takes priority over `frame_done`.

Top module: `aud_stat_ctrl`

## Requirements
- R1: After reset `rd_data` is 0 (with both FIFO level inputs low), and `irq`, `dma_req`, `fifo_rst`, `dir_rst` and `dir_en` are all 0.
- R2: The enable fields read back as written. Bit 0 is the DMA request enable. Bits 8 to 12 are the interrupt enables for word start, sync error, FIFO error, FIFO warning and FIFO request, in that order.
- R3: Word start, sync error and FIFO error are sticky flags at bits 16, 17 and 18. A one-cycle pulse on `evt_word_start`, `evt_sync_err` or `evt_fifo_err` sets the flag, which reads as 1 after the next clock edge. A write with that bit at 1 clears the flag. A write with that bit at 0 leaves it unchanged.
- R4: If an event pulse and a write-1 clear of the same flag arrive in the same cycle, the flag stays set.
- R5: Bit 19 (FIFO warning) and bit 20 (FIFO request) follow `lvl_fifo_warn` and `lvl_fifo_req` with no delay. Writes to these bits have no effect.
- R6: `irq` is 1 exactly when some flag in bits 16 to 20 is 1 and the enable 8 positions below it is 1. A flag whose enable is 0 does not raise `irq`.
- R7: `dma_req` is 1 only when bit 0 is 1 and `lvl_fifo_req` is 1.
- R8: A write with bit 25 at 1 makes `fifo_rst` high for exactly the one cycle after the write edge. Bit 25 always reads as 0.
- R9: Bit 24 reads back as written and drives `dir_rst`. While it is 1:
  - the sticky flags are cleared and held at 0, and event pulses are ignored;
  - the enable machine is forced to `EN_IDLE`.
  Writing 0 to bit 24 releases the direction.
- R10: Bit 31 and `dir_en` show whether the enable machine is outside `EN_IDLE`.
  - A write with bit 31 = 1 sets them from the next cycle.
  - A write with bit 31 = 0 keeps them at 1 until a `frame_end` pulse; they read 0 from the cycle after that pulse.
  - A `frame_end` pulse while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current status word |
| evt_word_start | input | 1 | Word start pulse from the serializer |
| evt_sync_err | input | 1 | Frame sync error pulse |
| evt_fifo_err | input | 1 | FIFO underrun/overflow pulse |
| lvl_fifo_warn | input | 1 | FIFO empty (transmit) or full (receive) level |
| lvl_fifo_req | input | 1 | FIFO watermark reached level |
| frame_end | input | 1 | End of frame pulse from the serializer |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Gated DMA request |
| fifo_rst | output | 1 | One-cycle FIFO pointer reset |
| dir_rst | output | 1 | Direction reset level |
| dir_en | output | 1 | Direction enable to the serializer |

## Verification
Each result has a fixed delay after its stimulus:
- Register fields, sticky flags, `fifo_rst` and the enable state change on the clock edge that samples the write or event. The bench drives every stimulus on a falling edge and reads the result on the next falling edge.
- The level flags, `irq` and `dma_req` follow the level inputs with no clock. For these the bench changes the input and reads one nanosecond later, inside the same cycle.
- Under software reset the sticky flags and the enable state are cleared one edge after the reset bit lands. Those checks therefore wait one more cycle.
- The single-cycle width of `fifo_rst` is checked by reading it again one cycle after the pulse.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;
    localparam int DATA_W     = 32;
    localparam int N_STICKY   = 3;
    localparam int N_LEVEL    = 2;
    localparam int N_FLAGS    = N_STICKY + N_LEVEL;
    localparam int ENA_LSB    = 8;
    localparam int FLG_LSB    = 16;
    localparam int EN_OFFSET  = FLG_LSB - ENA_LSB;
    localparam int DMA_EN_BIT = 0;
    localparam int SWRST_BIT  = 24;
    localparam int FRST_BIT   = 25;
    localparam int ENABLE_BIT = 31;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_RUN   = 2'd1,
        EN_DRAIN = 2'd2
    } en_state_t;
endpackage

// File: rtl/aud_stat_flags.sv
module aud_stat_flags #(
    parameter int NSTICKY = 3,
    parameter int NLEVEL  = 2,
    localparam int NALL   = NSTICKY + NLEVEL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_clr,
    input  logic [NSTICKY-1:0] evt,
    input  logic [NSTICKY-1:0] w1c,
    input  logic [NLEVEL-1:0]  lvl,
    output logic [NALL-1:0]    flags
);
    logic [NSTICKY-1:0] sticky_q;

    for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky_q[i] <= 1'b0;
            end else if (hold_clr) begin
                sticky_q[i] <= 1'b0;
            end else if (evt[i]) begin
                sticky_q[i] <= 1'b1;
            end else if (w1c[i]) begin
                sticky_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        flags = {lvl, sticky_q};
    end
endmodule

// File: rtl/aud_stat_en_fsm.sv
module aud_stat_en_fsm
    import aud_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic wr_go,
    input  logic wr_stop,
    input  logic frame_end,
    output logic en_out
);
    en_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (sw_rst) begin
            state_d = EN_IDLE;
        end else begin
            unique case (state_q)
                EN_IDLE: begin
                    if (wr_go) state_d = EN_RUN;
                end
                EN_RUN: begin
                    if (wr_stop) state_d = EN_DRAIN;
                end
                EN_DRAIN: begin
                    if (wr_go) state_d = EN_RUN;
                    else if (frame_end) state_d = EN_IDLE;
                end
                default: state_d = EN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        en_out = (state_q != EN_IDLE);
    end
endmodule

// File: rtl/aud_stat_ctrl.sv
module aud_stat_ctrl
    import aud_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt_word_start,
    input  logic              evt_sync_err,
    input  logic              evt_fifo_err,
    input  logic              lvl_fifo_warn,
    input  logic              lvl_fifo_req,
    input  logic              frame_end,
    output logic              irq,
    output logic              dma_req,
    output logic              fifo_rst,
    output logic              dir_rst,
    output logic              dir_en
);
    logic               dma_en_q;
    logic [N_FLAGS-1:0] irq_en_q;
    logic               swrst_q;
    logic               frst_q;
    logic [N_FLAGS-1:0] flags;
    logic [N_STICKY-1:0] w1c;
    logic               unused_wr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en_q <= 1'b0;
            irq_en_q <= '0;
            swrst_q  <= 1'b0;
            frst_q   <= 1'b0;
        end else begin
            frst_q <= wr_en & wr_data[FRST_BIT];
            if (wr_en) begin
                dma_en_q <= wr_data[DMA_EN_BIT];
                irq_en_q <= wr_data[ENA_LSB +: N_FLAGS];
                swrst_q  <= wr_data[SWRST_BIT];
            end
        end
    end

    always_comb begin
        w1c = wr_en ? wr_data[FLG_LSB +: N_STICKY] : '0;
    end

    aud_stat_flags #(
        .NSTICKY(N_STICKY),
        .NLEVEL (N_LEVEL)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_clr(swrst_q),
        .evt     ({evt_fifo_err, evt_sync_err, evt_word_start}),
        .w1c     (w1c),
        .lvl     ({lvl_fifo_req, lvl_fifo_warn}),
        .flags   (flags)
    );

    aud_stat_en_fsm u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (swrst_q),
        .wr_go    (wr_en & wr_data[ENABLE_BIT]),
        .wr_stop  (wr_en & ~wr_data[ENABLE_BIT]),
        .frame_end(frame_end),
        .en_out   (dir_en)
    );

    always_comb begin
        rd_data                        = '0;
        rd_data[DMA_EN_BIT]            = dma_en_q;
        rd_data[ENA_LSB +: N_FLAGS]    = irq_en_q;
        rd_data[FLG_LSB +: N_FLAGS]    = flags;
        rd_data[SWRST_BIT]             = swrst_q;
        rd_data[ENABLE_BIT]            = dir_en;
        irq      = |(flags & irq_en_q);
        dma_req  = dma_en_q & flags[N_FLAGS-1];
        fifo_rst = frst_q;
        dir_rst  = swrst_q;
    end

    assign unused_wr_bits = ^{wr_data[ENA_LSB-1:DMA_EN_BIT+1],
                              wr_data[FLG_LSB-1:ENA_LSB+N_FLAGS],
                              wr_data[SWRST_BIT-1:FLG_LSB+N_STICKY],
                              wr_data[ENABLE_BIT-1:FRST_BIT+1]};
endmodule

// File: rtl/aud_stat_chk.sv
module aud_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        evt_word_start,
    input logic        frame_end,
    input logic        irq,
    input logic        dma_req,
    input logic        fifo_rst,
    input logic        dir_en
);
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[16] && !evt_word_start) |=> !rd_data[16]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word_start && !rd_data[24]) |=> rd_data[16]);

    a_r6_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !(|rd_data[20:16]) |-> !irq);

    a_r7_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (rd_data[0] && rd_data[20]));

    a_r8_fifo_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25]) |=> fifo_rst);

    a_r9_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[24] |=> !dir_en);

    a_r10_hold_to_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && !frame_end && !rd_data[24]) |=> dir_en);
endmodule

bind aud_stat_ctrl aud_stat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .evt_word_start(evt_word_start),
    .frame_end     (frame_end),
    .irq           (irq),
    .dma_req       (dma_req),
    .fifo_rst      (fifo_rst),
    .dir_en        (dir_en)
);

// File: tb/aud_stat_ctrl_tb_top.sv
`timescale 1ns/1ps
module aud_stat_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        evt_word_start = 1'b0, evt_sync_err = 1'b0, evt_fifo_err = 1'b0;
    logic        lvl_fifo_warn = 1'b0, lvl_fifo_req = 1'b0, frame_end = 1'b0;
    logic        irq, dma_req, fifo_rst, dir_rst, dir_en;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    aud_stat_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .evt_word_start(evt_word_start),
        .evt_sync_err(evt_sync_err), .evt_fifo_err(evt_fifo_err),
        .lvl_fifo_warn(lvl_fifo_warn), .lvl_fifo_req(lvl_fifo_req),
        .frame_end(frame_end), .irq(irq), .dma_req(dma_req),
        .fifo_rst(fifo_rst), .dir_rst(dir_rst), .dir_en(dir_en)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_evt(input int which);
        case (which)
            0: evt_word_start = 1'b1;
            1: evt_sync_err   = 1'b1;
            default: evt_fifo_err = 1'b1;
        endcase
        @(negedge clk);
        evt_word_start = 1'b0; evt_sync_err = 1'b0; evt_fifo_err = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 outputs", {27'd0, irq, dma_req, fifo_rst, dir_rst, dir_en}, 32'h0);
    endtask

    task automatic t_layout;
        wr(32'h0000_1F01);
        check("R2 all enables", rd_data, 32'h0000_1F01);
        wr(32'h0000_0A00);
        check("R2 partial enables", rd_data, 32'h0000_0A00);
        wr(32'h0);
        check("R2 cleared", rd_data, 32'h0);
    endtask

    task automatic t_sticky;
        pulse_evt(0);
        check("R3 word start", rd_data[18:16], 3'b001);
        pulse_evt(1);
        pulse_evt(2);
        check("R3 all sticky", rd_data[18:16], 3'b111);
        wr(32'h0);
        check("R3 write 0 keeps", rd_data[18:16], 3'b111);
        wr(32'h0002_0000);
        check("R3 w1c sync err", rd_data[18:16], 3'b101);
        wr(32'h0005_0000);
        check("R3 w1c rest", rd_data[18:16], 3'b000);
    endtask

    task automatic t_collide;
        evt_word_start = 1'b1;
        wr(32'h0001_0000);
        evt_word_start = 1'b0;
        check("R4 set wins", rd_data[16], 1'b1);
        wr(32'h0001_0000);
        check("R4 later clear", rd_data[16], 1'b0);
    endtask

    task automatic t_levels;
        lvl_fifo_warn = 1'b1; #1;
        check("R5 warn follows", rd_data[20:19], 2'b01);
        @(negedge clk);
        wr(32'h0018_0000);
        check("R5 write ignored", rd_data[20:19], 2'b01);
        lvl_fifo_warn = 1'b0; lvl_fifo_req = 1'b1; #1;
        check("R5 req follows", rd_data[20:19], 2'b10);
        lvl_fifo_req = 1'b0; #1;
        check("R5 both low", rd_data[20:19], 2'b00);
        @(negedge clk);
    endtask

    task automatic t_irq;
        wr(32'h0000_0200);
        pulse_evt(0);
        check("R6 masked flag", irq, 1'b0);
        pulse_evt(1);
        check("R6 enabled flag", irq, 1'b1);
        wr(32'h0003_0200);
        check("R6 cleared", irq, 1'b0);
        wr(32'h0000_1000);
        lvl_fifo_req = 1'b1; #1;
        check("R6 level irq", irq, 1'b1);
        lvl_fifo_req = 1'b0; #1;
        check("R6 level gone", irq, 1'b0);
        @(negedge clk);
        wr(32'h0);
    endtask

    task automatic t_dma;
        lvl_fifo_req = 1'b1;
        wr(32'h0000_0001);
        check("R7 dma on", dma_req, 1'b1);
        wr(32'h0);
        check("R7 dma gated", dma_req, 1'b0);
        wr(32'h0000_0001);
        lvl_fifo_req = 1'b0; #1;
        check("R7 no watermark", dma_req, 1'b0);
        @(negedge clk);
        wr(32'h0);
    endtask

    task automatic t_fiforst;
        check("R8 idle", fifo_rst, 1'b0);
        wr(32'h0200_0000);
        check("R8 pulse", fifo_rst, 1'b1);
        check("R8 reads 0", rd_data[25], 1'b0);
        @(negedge clk);
        check("R8 one cycle", fifo_rst, 1'b0);
    endtask

    task automatic t_softrst;
        wr(32'h8000_0000);
        pulse_evt(0);
        wr(32'h8100_0000);
        check("R9 bit reads", rd_data[24], 1'b1);
        check("R9 dir_rst", dir_rst, 1'b1);
        @(negedge clk);
        check("R9 flag cleared", rd_data[16], 1'b0);
        check("R9 enable forced", dir_en, 1'b0);
        pulse_evt(0);
        check("R9 event ignored", rd_data[16], 1'b0);
        wr(32'h0);
        check("R9 released", dir_rst, 1'b0);
        pulse_evt(0);
        check("R9 event after", rd_data[16], 1'b1);
        wr(32'h0001_0000);
    endtask

    task automatic t_enable;
        wr(32'h8000_0000);
        check("R10 go", {rd_data[31], dir_en}, 2'b11);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        check("R10 frame while run", dir_en, 1'b1);
        wr(32'h0);
        check("R10 drain holds", {rd_data[31], dir_en}, 2'b11);
        idle(3);
        check("R10 drain waits", dir_en, 1'b1);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        check("R10 frame done", {rd_data[31], dir_en}, 2'b00);
        wr(32'h8000_0000);
        wr(32'h0);
        wr(32'h8000_0000);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        check("R10 restart wins", dir_en, 1'b1);
        wr(32'h0);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        check("R10 final off", dir_en, 1'b0);
    endtask

    initial begin
        fork
            begin
                #10; @(negedge clk); rst_n = 1'b1; @(negedge clk);
                t_reset();
                t_layout();
                t_sticky();
                t_collide();
                t_levels();
                t_irq();
                t_dma();
                t_fiforst();
                t_softrst();
                t_enable();
            end
            begin
                #100000;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule